// File: doc/BRIEF.md
# Streaming Ring Energy-Sum Accumulator

This block reduces a time-multiplexed calorimeter tower stream to event-level energy quantities. Each accepted beat carries one η ring: `NPHI` unsigned tower energies, one per φ position. Every beat is turned into four per-ring values: the scalar energy, the x and y components of the vector energy, and the number of towers above a threshold. The x and y components come from fixed cosine and sine weights. A pipelined adder tree reduces each quantity over φ in strips of 3, 9, 18, 36 and then 72 towers. The ring values are then summed over η as the rings arrive.

The caller marks the first ring of an event with `in_sof` and the last ring with `in_eof`. After the last ring has passed through the pipeline, the four event totals appear on the output stream. The input and output are valid/ready streams. A beat moves when valid and ready are both high at a rising edge. A result that has not been taken stalls the whole pipeline and lowers `in_ready`. `in_valid` may be held through such a stall, and the sending side must keep its beat unchanged until it is accepted. Throughput is one ring per cycle while `out_ready` stays high.

The threshold is a plain control input. It is sampled on the edge that accepts a ring.

Top module: `rs_ring_sums`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0, `in_ready` is 1 and the output sums read 0.
- R2: `out_et` equals the sum of every tower energy of every ring accepted from the ring flagged `in_sof` up to and including the ring flagged `in_eof`.
- R3: Tower i is `in_et[i*EW +: EW]` and sits at angle a = 2π(i+0.5)/NPHI. Its weights are C = round(cos a·(2^(CW-1)−1)) and S = round(sin a·(2^(CW-1)−1)), with halves rounded away from zero. Its x term is floor((e·C + 2^(CW-2)) / 2^(CW-1)), and its y term uses S the same way. `out_ex` and `out_ey` are the signed event sums of these terms.
- R4: `out_cnt` counts the towers of the event whose energy is strictly greater than `thr`, where `thr` is the value present on the accepting edge.
- R5: A ring flagged `in_sof` discards everything accumulated before it, whether or not the earlier rings ended with `in_eof`. A ring flagged with both `in_sof` and `in_eof` forms a one-ring event.
- R6: Each accepted `in_eof` ring produces exactly one result. With `out_ready` high, `out_valid` rises on the (LEVELS+1)-th rising edge after the edge that accepts the last ring.
- R7: While `out_valid` is 1 and `out_ready` is 0, all outputs hold their values and `in_ready` is 0.
- R8: Cycles with `in_valid` low leave every sum unchanged.
- R9: The accumulators saturate and do not wrap. `out_et` saturates at 2^ACC_W−1, `out_cnt` at 2^CNT_W−1, and `out_ex`/`out_ey` at +(2^(ACC_W-1)−1) or −2^(ACC_W-1). Saturation is applied as each ring is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr | input | EW | Counting threshold |
| in_valid | input | 1 | Ring beat valid |
| in_ready | output | 1 | Ring beat may be accepted |
| in_sof | input | 1 | First ring of an event |
| in_eof | input | 1 | Last ring of an event |
| in_et | input | NPHI*EW | Tower energies, φ index i at bits i*EW |
| out_valid | output | 1 | Event result valid |
| out_ready | input | 1 | Result accepted |
| out_et | output | ACC_W | Scalar energy sum |
| out_ex | output | ACC_W | Signed x vector sum |
| out_ey | output | ACC_W | Signed y vector sum |
| out_cnt | output | CNT_W | Towers above threshold |

## Verification
The hardest state to reach from the ports is a signed vector accumulator that sits at its positive or negative limit. Random rings mostly cancel in φ, so they rarely push it there. The stimulus gets there with event streams that light only the towers whose cosine or sine weight has one sign, which drives each component steadily to one bound. Separate events fill every tower to its maximum with a zero threshold, which pushes the scalar sum and the counter into saturation. Back-pressure and input bubbles are laid over multi-ring events so that stalls land in the middle of the pipeline. Restarts that abandon a partial event test that a new start flag clears the earlier sums.

// File: rtl/rs_pkg.sv
package rs_pkg;

  // reduction factor of tree level lvl (1-based): strips of 3, 9, then doubling
  function automatic int rs_factor(input int lvl);
    return (lvl <= 2) ? 3 : 2;
  endfunction

  // number of towers covered by one node at level lvl
  function automatic int rs_span(input int lvl);
    int s = 1;
    for (int m = 1; m <= lvl; m++) s = s * rs_factor(m);
    return s;
  endfunction

  // first node index of level lvl inside the flattened node array
  function automatic int rs_offset(input int n, input int lvl);
    int o = 0;
    for (int m = 1; m < lvl; m++) o = o + n / rs_span(m);
    return o;
  endfunction

  // fixed-point trigonometric weight for phi index idx
  function automatic int rs_coef(input int idx, input int n, input int cw, input bit use_sin);
    real ang;
    real v;
    ang = 6.283185307179586 * (real'(idx) + 0.5) / real'(n);
    v = (use_sin ? $sin(ang) : $cos(ang)) * (2.0 ** (cw - 1) - 1.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction

endpackage

// File: rtl/rs_phi_weight.sv
module rs_phi_weight
  import rs_pkg::*;
#(
  parameter int N  = 72,
  parameter int EW = 8,
  parameter int CW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [N*EW-1:0]   towers,
  input  logic [EW-1:0]     thr,
  output logic [N*(EW+1)-1:0] et_q,
  output logic [N*(EW+1)-1:0] x_q,
  output logic [N*(EW+1)-1:0] y_q,
  output logic [N-1:0]      hit_q
);
  localparam int PW = EW + 1 + CW;
  localparam int FR = CW - 1;
  localparam logic signed [PW-1:0] HALF = PW'(2 ** (FR - 1));

  for (genvar i = 0; i < N; i++) begin : g_tw
    localparam logic signed [CW-1:0] CC = CW'(rs_coef(i, N, CW, 1'b0));
    localparam logic signed [CW-1:0] CS = CW'(rs_coef(i, N, CW, 1'b1));
    logic [EW-1:0]          e;
    logic signed [PW-1:0]   pc, ps;
    logic signed [EW:0]     rc, rsn;
    assign e   = towers[i*EW +: EW];
    assign pc  = PW'($signed({1'b0, e})) * PW'(CC);
    assign ps  = PW'($signed({1'b0, e})) * PW'(CS);
    assign rc  = (EW+1)'((pc + HALF) >>> FR);
    assign rsn = (EW+1)'((ps + HALF) >>> FR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        et_q[i*(EW+1) +: EW+1] <= '0;
        x_q[i*(EW+1) +: EW+1]  <= '0;
        y_q[i*(EW+1) +: EW+1]  <= '0;
        hit_q[i]               <= 1'b0;
      end else if (en) begin
        et_q[i*(EW+1) +: EW+1] <= {1'b0, e};
        x_q[i*(EW+1) +: EW+1]  <= rc;
        y_q[i*(EW+1) +: EW+1]  <= rsn;
        hit_q[i]               <= (e > thr);
      end
    end

    logic signed [EW:0] xs, es;
    assign xs = x_q[i*(EW+1) +: EW+1];
    assign es = et_q[i*(EW+1) +: EW+1];
    AST_VEC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(xs) <= int'(es)) && (-int'(xs) <= int'(es)));  // R3
  end

endmodule

// File: rtl/rs_strip_tree.sv
module rs_strip_tree
  import rs_pkg::*;
#(
  parameter int N      = 72,
  parameter int LEVELS = 5,
  parameter int IW     = 9,
  parameter int W      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [N*IW-1:0]     leaf,
  output logic signed [W-1:0] total
);
  localparam int TOT = rs_offset(N, LEVELS + 1);

  logic signed [W-1:0] node_q [TOT];
  logic signed [W-1:0] node_d [TOT];

  for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
    localparam int F    = rs_factor(l);
    localparam int CNT  = N / rs_span(l);
    localparam int OFF  = rs_offset(N, l);
    localparam int POFF = rs_offset(N, l - 1);
    for (genvar j = 0; j < CNT; j++) begin : g_node
      logic signed [W-1:0] term [F];
      for (genvar k = 0; k < F; k++) begin : g_term
        if (l == 1) begin : g_leaf
          assign term[k] = W'($signed(leaf[(j*F+k)*IW +: IW]));
        end else begin : g_inner
          assign term[k] = node_q[POFF + j*F + k];
        end
      end
      if (F == 3) begin : g_f3
        assign node_d[OFF+j] = term[0] + term[1] + term[2];
      end else begin : g_f2
        assign node_d[OFF+j] = term[0] + term[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOT; i++) node_q[i] <= '0;
    end else if (en) begin
      node_q <= node_d;
    end
  end

  assign total = node_q[TOT-1];

endmodule

// File: rtl/rs_eta_accum.sv
module rs_eta_accum #(
  parameter int TW    = 17,
  parameter int VW    = 17,
  parameter int CNW   = 9,
  parameter int ACC_W = 18,
  parameter int CNT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    tag_v,
  input  logic                    tag_sof,
  input  logic signed [TW-1:0]    ring_et,
  input  logic signed [VW-1:0]    ring_x,
  input  logic signed [VW-1:0]    ring_y,
  input  logic signed [CNW-1:0]   ring_cnt,
  output logic [ACC_W-1:0]        sum_et,
  output logic signed [ACC_W-1:0] sum_x,
  output logic signed [ACC_W-1:0] sum_y,
  output logic [CNT_W-1:0]        sum_cnt
);
  localparam int M1 = (ACC_W > TW) ? ACC_W : TW;
  localparam int M2 = (VW > CNW) ? VW : CNW;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int SW = ((M3 > CNT_W) ? M3 : CNT_W) + 2;
  localparam logic signed [SW-1:0] UMAX = SW'({ACC_W{1'b1}});
  localparam logic signed [SW-1:0] SMAX = SW'({(ACC_W-1){1'b1}});
  localparam logic signed [SW-1:0] SMIN = -SMAX - SW'(1);
  localparam logic signed [SW-1:0] CMAX = SW'({CNT_W{1'b1}});

  logic [ACC_W-1:0]        acc_et;
  logic signed [ACC_W-1:0] acc_x, acc_y;
  logic [CNT_W-1:0]        acc_cnt;
  logic signed [SW-1:0]    e_w, x_w, y_w, c_w;

  always_comb begin
    e_w = (tag_sof ? '0 : SW'($signed({1'b0, acc_et})))  + SW'(ring_et);
    x_w = (tag_sof ? '0 : SW'(acc_x))                    + SW'(ring_x);
    y_w = (tag_sof ? '0 : SW'(acc_y))                    + SW'(ring_y);
    c_w = (tag_sof ? '0 : SW'($signed({1'b0, acc_cnt}))) + SW'(ring_cnt);
    sum_et  = (e_w > UMAX) ? ACC_W'(UMAX) : ACC_W'(e_w);
    sum_cnt = (c_w > CMAX) ? CNT_W'(CMAX) : CNT_W'(c_w);
    if (x_w > SMAX)      sum_x = ACC_W'(SMAX);
    else if (x_w < SMIN) sum_x = ACC_W'(SMIN);
    else                 sum_x = ACC_W'(x_w);
    if (y_w > SMAX)      sum_y = ACC_W'(SMAX);
    else if (y_w < SMIN) sum_y = ACC_W'(SMIN);
    else                 sum_y = ACC_W'(y_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_et  <= '0;
      acc_x   <= '0;
      acc_y   <= '0;
      acc_cnt <= '0;
    end else if (en && tag_v) begin
      acc_et  <= sum_et;
      acc_x   <= sum_x;
      acc_y   <= sum_y;
      acc_cnt <= sum_cnt;
    end
  end

  AST_ET_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tag_v && !tag_sof) |=> (acc_et >= $past(acc_et)));  // R9
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tag_v && !tag_sof) |=> (acc_cnt >= $past(acc_cnt)));  // R9
  AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tag_v && tag_sof) |=> (int'(acc_et) <= int'($past(ring_et))));  // R5

endmodule

// File: rtl/rs_ring_sums.sv
module rs_ring_sums #(
  parameter int NPHI   = 72,
  parameter int LEVELS = 5,
  parameter int EW     = 8,
  parameter int CW     = 12,
  parameter int ACC_W  = 18,
  parameter int CNT_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [EW-1:0]           thr,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_sof,
  input  logic                    in_eof,
  input  logic [NPHI*EW-1:0]      in_et,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [ACC_W-1:0]        out_et,
  output logic signed [ACC_W-1:0] out_ex,
  output logic signed [ACC_W-1:0] out_ey,
  output logic [CNT_W-1:0]        out_cnt
);
  localparam int LOGN = $clog2(NPHI);
  localparam int TW   = EW + 2 + LOGN;
  localparam int VW   = EW + 2 + LOGN;
  localparam int CNW  = LOGN + 2;

  logic adv;
  assign adv      = !(out_valid && !out_ready);
  assign in_ready = adv;

  // stage 0: per-tower weighting
  logic [NPHI*(EW+1)-1:0] et_w, x_w, y_w;
  logic [NPHI-1:0]        hit_w;
  logic [NPHI*2-1:0]      hit2;

  rs_phi_weight #(.N(NPHI), .EW(EW), .CW(CW)) u_weight (
    .clk(clk), .rst_n(rst_n), .en(adv), .towers(in_et), .thr(thr),
    .et_q(et_w), .x_q(x_w), .y_q(y_w), .hit_q(hit_w)
  );

  for (genvar i = 0; i < NPHI; i++) begin : g_hit
    assign hit2[i*2 +: 2] = {1'b0, hit_w[i]};
  end

  // phi reduction trees
  logic signed [TW-1:0]  ring_et;
  logic signed [VW-1:0]  ring_x, ring_y;
  logic signed [CNW-1:0] ring_cnt;

  rs_strip_tree #(.N(NPHI), .LEVELS(LEVELS), .IW(EW+1), .W(TW)) u_tree_et (
    .clk(clk), .rst_n(rst_n), .en(adv), .leaf(et_w), .total(ring_et));
  rs_strip_tree #(.N(NPHI), .LEVELS(LEVELS), .IW(EW+1), .W(VW)) u_tree_x (
    .clk(clk), .rst_n(rst_n), .en(adv), .leaf(x_w), .total(ring_x));
  rs_strip_tree #(.N(NPHI), .LEVELS(LEVELS), .IW(EW+1), .W(VW)) u_tree_y (
    .clk(clk), .rst_n(rst_n), .en(adv), .leaf(y_w), .total(ring_y));
  rs_strip_tree #(.N(NPHI), .LEVELS(LEVELS), .IW(2), .W(CNW)) u_tree_cnt (
    .clk(clk), .rst_n(rst_n), .en(adv), .leaf(hit2), .total(ring_cnt));

  // frame tags travel alongside the data
  logic tag_v [LEVELS+1];
  logic tag_s [LEVELS+1];
  logic tag_e [LEVELS+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k <= LEVELS; k++) begin
        tag_v[k] <= 1'b0;
        tag_s[k] <= 1'b0;
        tag_e[k] <= 1'b0;
      end
    end else if (adv) begin
      tag_v[0] <= in_valid;
      tag_s[0] <= in_valid && in_sof;
      tag_e[0] <= in_valid && in_eof;
      for (int k = 1; k <= LEVELS; k++) begin
        tag_v[k] <= tag_v[k-1];
        tag_s[k] <= tag_s[k-1];
        tag_e[k] <= tag_e[k-1];
      end
    end
  end

  // eta accumulation
  logic [ACC_W-1:0]        sum_et;
  logic signed [ACC_W-1:0] sum_x, sum_y;
  logic [CNT_W-1:0]        sum_cnt;

  rs_eta_accum #(.TW(TW), .VW(VW), .CNW(CNW), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .tag_v(tag_v[LEVELS]), .tag_sof(tag_s[LEVELS]),
    .ring_et(ring_et), .ring_x(ring_x), .ring_y(ring_y), .ring_cnt(ring_cnt),
    .sum_et(sum_et), .sum_x(sum_x), .sum_y(sum_y), .sum_cnt(sum_cnt)
  );

  // result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_et    <= '0;
      out_ex    <= '0;
      out_ey    <= '0;
      out_cnt   <= '0;
    end else if (adv && tag_v[LEVELS] && tag_e[LEVELS]) begin
      out_valid <= 1'b1;
      out_et    <= sum_et;
      out_ex    <= sum_x;
      out_ey    <= sum_y;
      out_cnt   <= sum_cnt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_et) && $stable(out_ex)
                                   && $stable(out_ey) && $stable(out_cnt)));  // R7

endmodule

// File: tb/sim_rs_ring_sums.sv
`timescale 1ns/1ps
module sim_rs_ring_sums;
  localparam int N  = 18;
  localparam int L  = 3;
  localparam int EW = 6;
  localparam int CW = 10;
  localparam int AW = 12;
  localparam int KW = 5;
  localparam int EMAX = (1 << EW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [EW-1:0]          thr = '0;
  logic                   in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic                   in_ready;
  logic [N*EW-1:0]        in_et = '0;
  logic                   out_valid;
  logic                   out_ready = 1'b1;
  logic [AW-1:0]          out_et;
  logic signed [AW-1:0]   out_ex, out_ey;
  logic [KW-1:0]          out_cnt;

  rs_ring_sums #(.NPHI(N), .LEVELS(L), .EW(EW), .CW(CW), .ACC_W(AW), .CNT_W(KW)) u0 (
    .clk(clk), .rst_n(rst_n), .thr(thr), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_eof(in_eof), .in_et(in_et), .out_valid(out_valid),
    .out_ready(out_ready), .out_et(out_et), .out_ex(out_ex), .out_ey(out_ey),
    .out_cnt(out_cnt));

  int n_chk = 0;
  int n_fail = 0;
  int n_events = 0;
  int n_results = 0;
  int cyc = 0;
  bit bp_en = 1'b0;
  bit mon_on = 1'b0;

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  // R3 weights and rounding computed from the stated formula
  function automatic int bcoef(input int i, input bit s);
    real a, v;
    a = 6.283185307179586 * (real'(i) + 0.5) / real'(N);
    v = (s ? $sin(a) : $cos(a)) * (2.0 ** (CW - 1) - 1.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction
  function automatic int rnd(input int p);
    return (p + (1 << (CW - 2))) >>> (CW - 1);
  endfunction
  function automatic int sat_u(input int v, input int w);
    return (v > (1 << w) - 1) ? (1 << w) - 1 : v;
  endfunction
  function automatic int sat_s(input int v);
    if (v > (1 << (AW - 1)) - 1) return (1 << (AW - 1)) - 1;
    if (v < -(1 << (AW - 1))) return -(1 << (AW - 1));
    return v;
  endfunction

  int m_et = 0, m_x = 0, m_y = 0, m_cnt = 0;
  int q_et[$], q_x[$], q_y[$], q_cnt[$];
  string q_tag[$];

  task automatic send_ring(input logic [N*EW-1:0] v, input bit sof, input bit eof,
                           input int gap, input string tag);
    int se = 0, sx = 0, sy = 0, sc = 0;
    bit done = 1'b0;
    for (int i = 0; i < N; i++) begin
      int e = int'(v[i*EW +: EW]);
      se += e;
      sx += rnd(e * bcoef(i, 1'b0));
      sy += rnd(e * bcoef(i, 1'b1));
      sc += (e > int'(thr)) ? 1 : 0;
    end
    if (sof) begin m_et = 0; m_x = 0; m_y = 0; m_cnt = 0; end
    m_et = sat_u(m_et + se, AW);
    m_x = sat_s(m_x + sx);
    m_y = sat_s(m_y + sy);
    m_cnt = sat_u(m_cnt + sc, KW);
    if (eof) begin
      q_et.push_back(m_et); q_x.push_back(m_x); q_y.push_back(m_y);
      q_cnt.push_back(m_cnt); q_tag.push_back(tag);
      n_events++;
    end
    in_valid = 1'b0;
    repeat (gap) begin @(posedge clk); #1; end
    in_et = v; in_sof = sof; in_eof = eof; in_valid = 1'b1;
    while (!done) begin
      @(negedge clk);
      if (in_ready) done = 1'b1;
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  // result monitor
  bit held = 1'b0;
  int h_et, h_x, h_y, h_cnt;
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (out_valid && !out_ready) begin
        chk("R7 in_ready during stall", int'(in_ready), 0);
        if (held) begin
          chk("R7 hold et", int'(out_et), h_et);
          chk("R7 hold ex", int'(out_ex), h_x);
          chk("R7 hold ey", int'(out_ey), h_y);
          chk("R7 hold cnt", int'(out_cnt), h_cnt);
        end
        held = 1'b1;
        h_et = int'(out_et); h_x = int'(out_ex); h_y = int'(out_ey); h_cnt = int'(out_cnt);
      end else begin
        held = 1'b0;
      end
      if (out_valid && out_ready) begin
        n_results++;
        if (q_et.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R6 unexpected result: actual 1 expected 0");
        end else begin
          string t;
          t = q_tag.pop_front();
          chk({t, " R2 et"}, int'(out_et), q_et.pop_front());
          chk({t, " R3 ex"}, int'(out_ex), q_x.pop_front());
          chk({t, " R3 ey"}, int'(out_ey), q_y.pop_front());
          chk({t, " R4 cnt"}, int'(out_cnt), q_cnt.pop_front());
        end
      end
    end
  end

  // back-pressure driver
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = bp_en ? ($urandom_range(0, 2) != 0) : 1'b1;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  function automatic logic [N*EW-1:0] fill(input int mode, input int v);
    logic [N*EW-1:0] r;
    for (int i = 0; i < N; i++) begin
      int e;
      case (mode)
        0: e = v;
        1: e = (v * (i + 1) + i * 7) % (EMAX + 1);
        2: e = $urandom_range(0, EMAX);
        3: e = (bcoef(i, 1'b0) > 0) ? EMAX : 0;
        4: e = (bcoef(i, 1'b0) < 0) ? EMAX : 0;
        5: e = (bcoef(i, 1'b1) > 0) ? EMAX : 0;
        default: e = (bcoef(i, 1'b1) < 0) ? EMAX : 0;
      endcase
      r[i*EW +: EW] = EW'(e);
    end
    return r;
  endfunction

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    chk("R1 in_ready in reset", int'(in_ready), 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk("R1 in_ready after reset", int'(in_ready), 1);
    chk("R1 out_et after reset", int'(out_et), 0);
    chk("R1 out_cnt after reset", int'(out_cnt), 0);
    mon_on = 1'b1;
    @(posedge clk); #1;

    // R6 latency on a one-ring event (also R5 sof+eof together)
    thr = 6'd10;
    send_ring(fill(0, 20), 1'b1, 1'b1, 0, "R6 latency");
    for (int k = 0; k <= L + 1; k++) begin
      @(negedge clk);
      chk("R6 latency out_valid", int'(out_valid), (k == L + 1) ? 1 : 0);
    end
    @(posedge clk); #1;

    // sweep of uniform and patterned one-ring events with varied thresholds
    for (int v = 0; v <= EMAX; v++) begin
      for (int p = 0; p < 2; p++) begin
        thr = EW'((v * 13 + p * 29) % (EMAX + 1));
        send_ring(fill(p, v), 1'b1, 1'b1, 0, "R2 R4 sweep");
      end
    end

    // R8 bubbles and R7 back-pressure over multi-ring events
    bp_en = 1'b1;
    for (int ev = 0; ev < 40; ev++) begin
      int nr = $urandom_range(1, 6);
      thr = EW'($urandom_range(0, EMAX));
      for (int r = 0; r < nr; r++)
        send_ring(fill(2, 0), r == 0, r == nr - 1, $urandom_range(0, 3), "R8 multi");
    end

    // R5 restart: a partial event is abandoned, then sof appears mid-event
    thr = 6'd30;
    for (int r = 0; r < 3; r++) send_ring(fill(2, 0), r == 0, 1'b0, 0, "R5 restart");
    send_ring(fill(2, 0), 1'b1, 1'b0, 1, "R5 restart");
    send_ring(fill(2, 0), 1'b1, 1'b0, 0, "R5 restart");
    send_ring(fill(2, 0), 1'b0, 1'b1, 0, "R5 restart");

    // R9 saturation: scalar, count, and both signs of each vector component
    thr = '0;
    for (int m = 0; m < 7; m++) begin
      int md = (m == 0) ? 0 : m;
      if (md == 1 || md == 2) continue;
      for (int r = 0; r < 8; r++)
        send_ring(fill(md, EMAX), r == 0, r == 7, 0, "R9 saturate");
    end
    bp_en = 1'b0;

    // drain
    for (int w = 0; w < 200 && q_et.size() != 0; w++) @(posedge clk);
    repeat (4) @(posedge clk);
    chk("R6 one result per eof", n_results, n_events);
    summary();
    $finish;
  end

endmodule